// File: doc/BRIEF.md
# Temporal Isolation Level Sequencer

This block holds a one-way boot privilege level. The level starts at its lowest stage when the block is reset. Each accepted command moves it up by exactly one stage. The level can never move down again except through another reset. Each stage is stored as a sparse 8-bit code rather than a binary count, so a single upset bit cannot turn one legal stage into another.

Software reaches the block through a simple word register port. The write and read sides are separate, and each has its own address. There are three word registers:

- a command register at byte offset 0x10, which requests one step up;
- a read-only status register at 0x14, which returns the current stage code;
- a next-index register at 0x18, which holds a 2-bit offset.

The block drives the current stage both as its code and as a 2-bit index. It also adds the next-index offset to the current stage and drives the result as the target storage stage. That sum is clamped at the top stage, and a flag is raised when it overflows.

Top module: `tiso_level_seq`

## Requirements
- R1: After reset the stage index is 0, the stage code is 0xB4, and the next index is 0.
- R2: The stage code output follows the index: index 0 gives 0xB4, 1 gives 0x51, 2 gives 0x8A and 3 gives 0x6F.
- R3: A write to offset 0x10 whose bits 7:0 equal 0xB4 leaves the stage unchanged.
- R4: A write to offset 0x10 with any other value in bits 7:0 raises the stage index by exactly one at that clock edge. Bits above 7 are not examined.
- R5: At stage index 3, command writes are ignored and the stage stays at 3. It never wraps.
- R6: A read of offset 0x14 returns the current stage code in bits 7:0 and zero in bits 31:8.
- R7: A write to offset 0x18 loads bits 1:0 into the next index. A read of 0x18 returns the next index in bits 1:0 and zero above.
- R8: The target output equals the stage index plus the next index. When that sum exceeds 3, the target is 3 and the invalid flag is 1; otherwise the flag is 0.
- R9: Writes to offset 0x14 change nothing. Reads of 0x10 and of any unmapped offset return zero.
- R10: Read data is combinational from the stored state. A status read in the same cycle as a stepping command write returns the stage code from before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr |
| lvl_code_o | output | 8 | Current stage code |
| lvl_idx_o | output | 2 | Current stage index |
| tgt_idx_o | output | 2 | Clamped target storage stage |
| tgt_invalid_o | output | 1 | Target sum exceeded the top stage |

## Verification
The read port and the write port are independent, so a status read and a stepping command can land in the same cycle. The bench provokes this by writing a stepping command to 0x10 while reading 0x14. It judges that cycle's read data against the pre-step code, and the following cycle against the stepped code. The same overlap exists between a next-index write and a level step that both reshape the target. These are provoked in succession and checked on every clock against the bench's own model.

// File: rtl/tiso_pkg.sv
package tiso_pkg;
  localparam int LVL_W  = 2;
  localparam int CODE_W = 8;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t NOOP_CMD = 8'hB4;
  localparam lvl_t  TOP_LVL  = lvl_t'((1 << LVL_W) - 1);

  // stage index -> sparse code
  function automatic code_t lvl_to_code(input lvl_t l);
    case (l)
      2'd0:    return 8'hB4;
      2'd1:    return 8'h51;
      2'd2:    return 8'h8A;
      default: return 8'h6F;
    endcase
  endfunction

  // sparse code -> stage index; an unknown code decodes as the top stage (fail locked)
  function automatic lvl_t code_to_lvl(input code_t c);
    case (c)
      8'hB4:   return 2'd0;
      8'h51:   return 2'd1;
      8'h8A:   return 2'd2;
      default: return TOP_LVL;
    endcase
  endfunction

  // widened sum so the overflow bit survives
  function automatic logic [LVL_W:0] wide_sum(input lvl_t a, input lvl_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/tiso_cmd_decode.sv
module tiso_cmd_decode
  import tiso_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 'h10,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h14,
  parameter logic [ADDR_W-1:0] OFS_NIDX = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              inc_req,
  output logic              nidx_we,
  output lvl_t              nidx_d
);
  logic  hit_cmd, hit_nidx;
  code_t cmd_byte;
  logic  unused_hi;

  assign hit_cmd   = wr_en && (wr_addr == OFS_CMD);
  assign hit_nidx  = wr_en && (wr_addr == OFS_NIDX);
  assign cmd_byte  = wr_data[CODE_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

  assign inc_req = hit_cmd && (cmd_byte != NOOP_CMD);
  assign nidx_we = hit_nidx;
  assign nidx_d  = wr_data[LVL_W-1:0];

  // R9
  stat_wr_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_STAT) |-> (!inc_req && !nidx_we));
  // R3
  noop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CODE_W-1:0] == 8'hB4) |-> !inc_req);
endmodule

// File: rtl/tiso_level_fsm.sv
module tiso_level_fsm
  import tiso_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_req,
  output code_t lvl_code,
  output lvl_t  lvl_idx
);
  code_t code_q, code_d;
  lvl_t  cur_lvl;
  logic  at_top;
  logic  step_ev;

  assign cur_lvl = code_to_lvl(code_q);
  assign at_top  = (cur_lvl == TOP_LVL);
  assign step_ev = inc_req && !at_top;

  always_comb begin
    code_d = code_q;
    if (step_ev) code_d = lvl_to_code(cur_lvl + lvl_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= lvl_to_code('0);
    else        code_q <= code_d;
  end

  assign lvl_code = code_q;
  assign lvl_idx  = cur_lvl;

  // R3
  hold_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_req |=> $stable(lvl_idx));
  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && lvl_idx != 2'd3) |=> (lvl_idx == $past(lvl_idx) + 2'd1));
  // R5
  top_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_idx == 2'd3) |=> (lvl_idx == 2'd3));
endmodule

// File: rtl/tiso_target_calc.sv
module tiso_target_calc
  import tiso_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t cur_lvl,
  input  lvl_t nidx,
  output lvl_t tgt,
  output logic tgt_invalid
);
  logic [LVL_W:0] sum;

  assign sum         = wide_sum(cur_lvl, nidx);
  assign tgt_invalid = sum[LVL_W];
  assign tgt         = tgt_invalid ? TOP_LVL : sum[LVL_W-1:0];

  // R8
  tgt_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_invalid |-> (tgt >= cur_lvl));
  // R8
  ovf_needs_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_invalid |-> (nidx != 2'd0 && cur_lvl != 2'd0));
endmodule

// File: rtl/tiso_level_seq.sv
module tiso_level_seq
  import tiso_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 'h10,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h14,
  parameter logic [ADDR_W-1:0] OFS_NIDX = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        lvl_code_o,
  output logic [1:0]        lvl_idx_o,
  output logic [1:0]        tgt_idx_o,
  output logic              tgt_invalid_o
);
  logic  inc_req, nidx_we;
  lvl_t  nidx_d, nidx_q, cur_lvl, tgt;
  code_t cur_code;
  logic  tgt_inv;

  tiso_cmd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_CMD(OFS_CMD), .OFS_STAT(OFS_STAT), .OFS_NIDX(OFS_NIDX)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .inc_req(inc_req), .nidx_we(nidx_we), .nidx_d(nidx_d)
  );

  tiso_level_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .inc_req(inc_req),
    .lvl_code(cur_code), .lvl_idx(cur_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nidx_q <= '0;
    else if (nidx_we) nidx_q <= nidx_d;
  end

  tiso_target_calc u_tgt (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .nidx(nidx_q),
    .tgt(tgt), .tgt_invalid(tgt_inv)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFS_STAT)      rd_data[CODE_W-1:0] = cur_code;
    else if (rd_addr == OFS_NIDX) rd_data[LVL_W-1:0]  = nidx_q;
  end

  assign lvl_code_o    = cur_code;
  assign lvl_idx_o     = cur_lvl;
  assign tgt_idx_o     = tgt;
  assign tgt_invalid_o = tgt_inv;

  // R7
  nidx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nidx_we |=> (rd_addr != OFS_NIDX || rd_data[1:0] == $past(wr_data[1:0])));
  // R10
  stat_prestep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == OFS_STAT) |-> (rd_data[7:0] == lvl_code_o));
endmodule

// File: tb/sim_tiso_level_seq.sv
module sim_tiso_level_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  lvl_code_o;
  logic [1:0]  lvl_idx_o, tgt_idx_o;
  logic        tgt_invalid_o;

  int checks = 0;
  int errors = 0;
  int m_lvl  = 0;
  int m_nidx = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tiso_level_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .lvl_code_o(lvl_code_o), .lvl_idx_o(lvl_idx_o),
    .tgt_idx_o(tgt_idx_o), .tgt_invalid_o(tgt_invalid_o)
  );

  function automatic logic [7:0] code_of(input int l);
    logic [31:0] tbl = {8'h6F, 8'h8A, 8'h51, 8'hB4};
    return tbl[8*l +: 8];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a == 8'h14) return {24'd0, code_of(m_lvl)};
    if (a == 8'h18) return 32'(m_nidx);
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string rtag);
    int s = m_lvl + m_nidx;
    chk("R2 code", 32'(lvl_code_o), 32'(code_of(m_lvl)));
    chk("R2 idx", 32'(lvl_idx_o), 32'(m_lvl));
    chk("R8 tgt", 32'(tgt_idx_o), 32'((s > 3) ? 3 : s));
    chk("R8 inv", 32'(tgt_invalid_o), 32'(s > 3));
    chk(rtag, rd_data, exp_rd(rd_addr));
  endtask

  task automatic cyc(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                     input logic [7:0] ra, input string rtag);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    #1;
    compare_all(rtag);
    @(posedge clk);
    if (we && wa == 8'h10 && wd[7:0] != 8'hB4 && m_lvl < 3) m_lvl++;
    if (we && wa == 8'h18) m_nidx = int'(wd[1:0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_addr = 8'h18;
    m_lvl = 0; m_nidx = 0;
    @(negedge clk); #1;
    chk("R1 code", 32'(lvl_code_o), 32'hB4);
    chk("R1 idx", 32'(lvl_idx_o), 32'd0);
    chk("R1 nidx", rd_data, 32'd0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    do_reset();
    cyc(0, 8'h00, 0, 8'h14, "R6 status");
    cyc(1, 8'h10, 32'hFFFF_FFB4, 8'h14, "R3 noop");
    cyc(0, 8'h00, 0, 8'h14, "R3 after noop");
    cyc(1, 8'h10, 32'h6A, 8'h14, "R10 prestep read");
    cyc(0, 8'h00, 0, 8'h14, "R4 stepped");
    cyc(1, 8'h18, 32'hFFFF_FFFE, 8'h18, "R7 nidx");
    cyc(0, 8'h00, 0, 8'h18, "R7 nidx readback");
    cyc(1, 8'h14, 32'hFFFF_FFFF, 8'h14, "R9 status write");
    cyc(0, 8'h00, 0, 8'h14, "R9 status unchanged");
    cyc(1, 8'h10, 32'h0, 8'h14, "R4 zero cmd");
    cyc(1, 8'h10, 32'hFFFF_FF01, 8'h14, "R4 high bits");
    cyc(1, 8'h10, 32'h6A, 8'h14, "R5 at top");
    cyc(1, 8'h10, 32'h55, 8'h14, "R5 at top again");
    cyc(0, 8'h00, 0, 8'h10, "R9 cmd read");
    cyc(0, 8'h00, 0, 8'h20, "R9 unmapped");
    cyc(1, 8'h18, 32'h0, 8'h18, "R7 nidx zero");
    cyc(1, 8'h18, 32'h3, 8'h18, "R8 nidx three");
    cyc(0, 8'h00, 0, 8'h18, "R8 clamp");
    do_reset();
    lf = 32'hACE1_1234;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[3:2])
        2'd0: cyc(1, 8'h10, (lf[4] ? 32'hB4 : lf), 8'h14, "R4 walk");
        2'd1: cyc(1, 8'h18, lf, 8'h18, "R7 walk");
        2'd2: cyc(1, 8'h14, lf, 8'h14, "R9 walk");
        default: cyc(0, 8'h00, 0, {2'b00, lf[9:5], 1'b0}, "R9 walk read");
      endcase
    end
    cyc(0, 8'h00, 0, 8'h14, "R6 final");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule